// File: doc/BRIEF.md
# Manual Bit-Slip Word Aligner

This block sits behind a deserializer and re-frames its parallel word stream. It keeps the previous input word next to the current one and cuts a window of word width out of that pair at a bit offset. An external controller raises a slip request whenever it wants the boundary moved. Each rising edge of that request moves the window by exactly one bit, so the controller can step through every boundary until the framing it wants appears.

Each output word is compared with an alignment pattern that arrives on an input port and may change at any time. A match raises a registered hit flag for exactly the output word that matched. The controller decides when to stop slipping, and it can retarget the hunt by changing the pattern, with no rebuild of the design.

Top module: `word_aligner_slip`

## Requirements
- R1: While reset is asserted, and after it is released, `word_o` is all zeros, `pat_hit_o` is low and the slip offset is 0. The stored previous word is also all zeros.
- R2: The offset advances by exactly one for each rising edge of `slip_req_i`, meaning low at one clock edge and high at the next. Holding the request high for any number of cycles causes no further advance.
- R3: Suppose `slip_req_i` is first sampled high at clock edge t. The output word registered at edge t+1 still uses the old offset. Words registered from edge t+2 onward use the new one.
- R4: At offset k, the word registered at an edge is bits [k+W-1:k] of the concatenation {previous input word, current input word}. Here the current word is `rx_word_i` sampled at that edge, and the previous word is the one sampled at the edge before. Offset 0 passes the input through unchanged. Each slip drops the current word's LSB side by one bit and feeds in the previous word's LSB at the MSB.
- R5: After W slips the offset wraps from W-1 back to 0, and the output again equals the input word.
- R6: `pat_hit_o` is registered in the same cycle as `word_o`. It is high exactly when that word equals `align_pat_i` as sampled at the same edge. A run of matching words gives one assertion per word, and the flag drops on the first word that does not match.
- R7: A change on `align_pat_i` applies to the very next registered output word, with no other action needed.
- R8: With W=8, pattern 8'b00111100 and a constant input of 8'b11110000, one slip gives an output of 8'b01111000 with `pat_hit_o` low. A second slip gives 8'b00111100 with `pat_hit_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_word_i | input | W | Parallel word from the deserializer |
| slip_req_i | input | 1 | Slip request; each rising edge moves the boundary one bit |
| align_pat_i | input | W | Alignment pattern, may change at run time |
| word_o | output | W | Re-framed output word |
| pat_hit_o | output | 1 | High for each output word that equals the pattern |

## Verification
The bench holds the slip request high for several cycles. A design that treats the request as a level would keep slipping and walk the word away from the expected value. It samples the output one and two cycles after a request edge, which exposes an off-by-one in the slip latency. It slips a full W times and expects the input word back, which catches a counter that overflows past W-1 or stalls there. It also changes the pattern while the data stays constant, and holds a matching word steady. A comparator working from a stale pattern, or a hit flag built as a one-shot, would then miss or hold the flag wrongly.

// File: rtl/wa_pkg.sv
package wa_pkg;
  // Depth of the reset release synchronizer.
  localparam int unsigned WA_RST_STAGES = 2;
  // Width of an offset counter able to index W bit positions.
  function automatic int unsigned wa_offw(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/wa_rst_sync.sv
module wa_rst_sync #(
  parameter int unsigned STAGES = wa_pkg::WA_RST_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/wa_slip_edge.sv
module wa_slip_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slip_req_i,
  output logic slip_step_o
);
  logic req_now_q, req_prev_q;
  logic req_now_d, req_prev_d;

  always_comb begin
    req_now_d  = slip_req_i;
    req_prev_d = req_now_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_now_q  <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      req_now_q  <= req_now_d;
      req_prev_q <= req_prev_d;
    end
  end

  assign slip_step_o = req_now_q & ~req_prev_q;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_step_o |=> !slip_step_o); // R2
endmodule

// File: rtl/wa_offset_ctr.sv
module wa_offset_ctr #(
  parameter int unsigned W    = 8,
  parameter int unsigned OFFW = wa_pkg::wa_offw(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  output logic [OFFW-1:0] off_o
);
  localparam logic [OFFW-1:0] LAST = OFFW'(W - 1);

  logic [OFFW-1:0] off_q, off_d;
  logic            off_en;

  always_comb begin
    off_en = step_i;
    off_d  = (off_q == LAST) ? '0 : off_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off_o = off_q;

  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= LAST); // R5
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(off_q)); // R2
  AST_OFF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && off_q == LAST) |=> off_q == '0); // R5
endmodule

// File: rtl/wa_window_sel.sv
module wa_window_sel #(
  parameter int unsigned W    = 8,
  parameter int unsigned OFFW = wa_pkg::wa_offw(W)
) (
  input  logic [2*W-1:0]  pair_i,
  input  logic [OFFW-1:0] off_i,
  output logic [W-1:0]    word_o
);
  logic [W-1:0] cand [W];

  for (genvar k = 0; k < W; k++) begin : g_cand
    assign cand[k] = pair_i[k +: W];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < W; k++) begin
      if (off_i == OFFW'(k)) word_o = cand[k];
    end
  end
endmodule

// File: rtl/wa_match.sv
module wa_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] pat_i,
  output logic         hit_o
);
  logic [W-1:0] bit_eq;

  for (genvar b = 0; b < W; b++) begin : g_eq
    assign bit_eq[b] = ~(word_i[b] ^ pat_i[b]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/word_aligner_slip.sv
module word_aligner_slip #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rx_word_i,
  input  logic         slip_req_i,
  input  logic [W-1:0] align_pat_i,
  output logic [W-1:0] word_o,
  output logic         pat_hit_o
);
  localparam int unsigned OFFW = wa_pkg::wa_offw(W);
  localparam int unsigned PAIRW = 2 * W;

  logic            rst_n;
  logic            slip_step;
  logic [OFFW-1:0] offset;
  logic [W-1:0]    prev_q, prev_d;
  logic [PAIRW-1:0] pair;
  logic [W-1:0]    word_sel;
  logic            hit_d;
  logic [W-1:0]    word_q;
  logic            hit_q;

  wa_rst_sync #(.STAGES(wa_pkg::WA_RST_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  wa_slip_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_n), .slip_req_i(slip_req_i),
    .slip_step_o(slip_step));

  wa_offset_ctr #(.W(W), .OFFW(OFFW)) u_off (
    .clk_i(clk_i), .rst_ni(rst_n), .step_i(slip_step), .off_o(offset));

  always_comb begin
    prev_d = rx_word_i;
    pair   = {prev_q, rx_word_i};
  end

  wa_window_sel #(.W(W), .OFFW(OFFW)) u_win (
    .pair_i(pair), .off_i(offset), .word_o(word_sel));

  wa_match #(.W(W)) u_cmp (
    .word_i(word_sel), .pat_i(align_pat_i), .hit_o(hit_d));

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      word_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      word_q <= word_sel;
      hit_q  <= hit_d;
    end
  end

  assign word_o    = word_q;
  assign pat_hit_o = hit_q;

  AST_HIT_IMPLIES_EQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    pat_hit_o |-> (word_o == $past(align_pat_i))); // R6
  AST_MISS_IMPLIES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (word_o != $past(align_pat_i)) |-> !pat_hit_o); // R7
  AST_ZERO_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (offset == '0 && !slip_step && $past(rst_n)) |=> (word_o == $past(rx_word_i))); // R4
endmodule

// File: tb/tb_word_aligner_slip.sv
module tb_word_aligner_slip;
  localparam int W = 8;
  localparam int NV = 20;
  // each entry: {input word, slip request, pattern}
  localparam logic [16:0] VEC [NV] = '{
    {8'hA5, 1'b0, 8'hA5}, {8'hA5, 1'b0, 8'hA5}, {8'h3C, 1'b1, 8'h00},
    {8'h3C, 1'b0, 8'h00}, {8'h3C, 1'b0, 8'h1E}, {8'h96, 1'b1, 8'h00},
    {8'h69, 1'b0, 8'h00}, {8'hC3, 1'b1, 8'h5A}, {8'h0F, 1'b0, 8'h00},
    {8'hF0, 1'b1, 8'h00}, {8'h55, 1'b1, 8'hAA}, {8'hAA, 1'b0, 8'h55},
    {8'hFF, 1'b1, 8'h00}, {8'h00, 1'b0, 8'h00}, {8'h81, 1'b1, 8'h7E},
    {8'h7E, 1'b0, 8'h81}, {8'h12, 1'b0, 8'h34}, {8'h34, 1'b1, 8'h12},
    {8'hE7, 1'b0, 8'hE7}, {8'hE7, 1'b0, 8'hE7}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] din;
  logic         slip;
  logic [W-1:0] pat;
  logic [W-1:0] word_o;
  logic         pat_hit_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state, built from the requirements
  logic [W-1:0] m_prev;
  int           m_off;
  logic         m_s1, m_s2;
  logic [W-1:0] m_word;
  logic         m_hit;

  always #5 clk = ~clk;

  word_aligner_slip #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_word_i(din), .slip_req_i(slip),
    .align_pat_i(pat), .word_o(word_o), .pat_hit_o(pat_hit_o));

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_prev = '0; m_off = 0; m_s1 = 1'b0; m_s2 = 1'b0;
    m_word = '0; m_hit = 1'b0;
  endtask

  task automatic model_edge(input logic [W-1:0] d, input logic s,
                            input logic [W-1:0] p);
    logic [2*W-1:0] pr;
    logic step;
    pr     = {m_prev, d};
    m_word = pr[m_off +: W];
    m_hit  = (m_word == p);
    step   = m_s1 & ~m_s2;
    if (step) m_off = (m_off == W - 1) ? 0 : m_off + 1;
    m_s2   = m_s1;
    m_s1   = s;
    m_prev = d;
  endtask

  task automatic step(input logic [W-1:0] d, input logic s,
                      input logic [W-1:0] p);
    din = d; slip = s; pat = p;
    @(posedge clk);
    model_edge(d, s, p);
    @(negedge clk);
  endtask

  task automatic do_reset();
    din = '0; slip = 1'b0; pat = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    din = '0; slip = 1'b0; pat = 8'hFF; rst_n = 1'b0;
    @(negedge clk);
    // R1: values during and after reset
    chk(word_o == '0, "R1 word in reset", word_o, '0);
    do_reset();
    chk(word_o == '0, "R1 word after reset", word_o, '0);
    chk(pat_hit_o == 1'b0, "R1 hit after reset", {7'd0, pat_hit_o}, '0);

    // R4: offset 0 passes input through
    step(8'hF0, 1'b0, 8'h3C);
    chk(word_o == 8'hF0, "R4 offset0 pass", word_o, 8'hF0);
    // R3: slip first sampled at edge t
    step(8'hF0, 1'b1, 8'h3C);
    step(8'hF0, 1'b1, 8'h3C);
    chk(word_o == 8'hF0, "R3 old offset at t+1", word_o, 8'hF0);
    step(8'hF0, 1'b1, 8'h3C);
    chk(word_o == 8'h78, "R3 R8 new offset at t+2", word_o, 8'h78);
    chk(pat_hit_o == 1'b0, "R8 no hit at 01111000", {7'd0, pat_hit_o}, '0);
    // R2: held high gives no more slips
    for (int i = 0; i < 4; i++) step(8'hF0, 1'b1, 8'h3C);
    chk(word_o == 8'h78, "R2 held level no slip", word_o, 8'h78);
    step(8'hF0, 1'b0, 8'h3C);
    step(8'hF0, 1'b1, 8'h3C);
    step(8'hF0, 1'b0, 8'h3C);
    step(8'hF0, 1'b0, 8'h3C);
    chk(word_o == 8'h3C, "R8 second slip word", word_o, 8'h3C);
    chk(pat_hit_o == 1'b1, "R8 hit on match", {7'd0, pat_hit_o}, 8'h01);
    step(8'hF0, 1'b0, 8'h3C);
    chk(pat_hit_o == 1'b1, "R6 hit per matching word", {7'd0, pat_hit_o}, 8'h01);
    // R7: pattern change applies to next word
    step(8'hF0, 1'b0, 8'h00);
    chk(pat_hit_o == 1'b0, "R7 new pattern no hit", {7'd0, pat_hit_o}, '0);
    chk(word_o == 8'h3C, "R7 word unchanged", word_o, 8'h3C);
    step(8'hF0, 1'b0, 8'h3C);
    chk(pat_hit_o == 1'b1, "R7 pattern restored hit", {7'd0, pat_hit_o}, 8'h01);
    // R5: six more slips from offset 2 wrap to offset 0
    for (int i = 0; i < 6; i++) begin
      step(8'hF0, 1'b1, 8'h3C);
      step(8'hF0, 1'b0, 8'h3C);
    end
    step(8'hF0, 1'b0, 8'h3C);
    step(8'hF0, 1'b0, 8'h3C);
    chk(word_o == 8'hF0, "R5 wrap to offset0", word_o, 8'hF0);
    chk(pat_hit_o == 1'b0, "R5 no hit after wrap", {7'd0, pat_hit_o}, '0);

    // table walk against the requirement model: R4 R6
    do_reset();
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][16:9], VEC[v][8], VEC[v][7:0]);
      chk(word_o == m_word, "R4 table word", word_o, m_word);
      chk(pat_hit_o == m_hit, "R6 table hit", {7'd0, pat_hit_o}, {7'd0, m_hit});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule